// File: doc/BRIEF.md
# DSP Lane Replicate and Halfword Reverse Unit

This is a combinational execute-stage slice for a 32-bit signal-processing instruction extension. From the instruction word it takes a 5-bit sub-operation field and produces one of four kinds of result. It can mirror the bit order of the low halfword of a source register. It can fill every byte lane with one byte, taken from an 8-bit immediate or from the low byte of the source register. It can also fill both halfword lanes with one halfword, taken from a sign-extended 10-bit immediate or from the low halfword of the source register.

Beside the result, the unit tells the surrounding pipeline what to do with it. A write-enable marks a result that belongs in the register file. A reserved-instruction flag marks a sub-operation code the unit does not know. A unit-disabled flag marks a known operation issued while the extension is switched off. A known operation aimed at destination index 0 is a silent no-op. The register file and the pipeline around the unit are outside its scope.

Top module: `dsp_bitrep_unit`

## Requirements
- R1: The sub-operation is read from instruction bits [10:6]. The known codes are 5'h1B (halfword reverse), 5'h02 (byte fill from immediate), 5'h03 (byte fill from register), 5'h0A (halfword fill from immediate) and 5'h0B (halfword fill from register). Every other code, including 5'h1A and 5'h1C, is unknown.
- R2: Halfword reverse sets result bit 15-k to source bit k for k in 0..15. Result bits [31:16] are zero and source bits [31:16] have no effect.
- R3: Byte fill from immediate copies instruction bits [23:16] into each of the four byte lanes of the result.
- R4: Byte fill from register copies source bits [7:0] into each of the four byte lanes.
- R5: Halfword fill from immediate sign-extends instruction bits [25:16] to 16 bits, with bit 25 as the sign bit, and places the value in both halfword lanes.
- R6: Halfword fill from register copies source bits [15:0] into both halfword lanes.
- R7: A known code with destination index 0 gives write-enable low, both flags low and a zero result, whatever the enable input is.
- R8: An unknown code raises the reserved-instruction flag, holds write-enable and the unit-disabled flag low and gives a zero result. This holds for any destination index and any enable level.
- R9: A known code with a nonzero destination index and the enable input low raises the unit-disabled flag, holds write-enable low and gives a zero result.
- R10: At most one of write-enable, reserved-instruction and unit-disabled is high at a time. The result is zero whenever write-enable is low, and write-enable is high exactly for a known code with a nonzero destination and the enable input high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Full instruction word |
| src_i | input | 32 | Source register value |
| dest_idx_i | input | 5 | Destination register index |
| dsp_en_i | input | 1 | Extension enabled |
| result_o | output | 32 | Computed result, zero when not written |
| wr_en_o | output | 1 | Result is to be written to the destination |
| rsvd_instr_o | output | 1 | Unknown sub-operation code |
| dsp_unusable_o | output | 1 | Known operation issued while disabled |

## Verification
The difficult part is the ordering between the three outcome conditions: an unknown code, destination index 0 and a disabled extension. A random draw seldom combines them in a way that tells the priorities apart. Directed cases therefore place an unknown code next to a disabled unit and next to destination 0, a disabled unit next to destination 0, and the unknown codes on either side of the reverse code. The random stimulus biases the code toward the five known values and draws index 0 and a low enable often enough to reach every pairing. The sign bit of the 10-bit immediate is forced both ways.

// File: rtl/dsp_bitrep_pkg.sv
package dsp_bitrep_pkg;

    localparam int unsigned SUBOP_W  = 5;
    localparam int unsigned IMM_W    = 10;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned HALF_W   = 16;

    localparam logic [SUBOP_W-1:0] CODE_REV     = 5'h1B;
    localparam logic [SUBOP_W-1:0] CODE_BYTE_IM = 5'h02;
    localparam logic [SUBOP_W-1:0] CODE_BYTE_RG = 5'h03;
    localparam logic [SUBOP_W-1:0] CODE_HALF_IM = 5'h0A;
    localparam logic [SUBOP_W-1:0] CODE_HALF_RG = 5'h0B;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_REV  = 2'd1,
        KIND_BYTE = 2'd2,
        KIND_HALF = 2'd3
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        logic     from_imm;
    } op_dec_t;

    typedef struct packed {
        logic write;
        logic rsvd;
        logic unusable;
    } op_ctl_t;

    function automatic op_dec_t decode_subop(input logic [SUBOP_W-1:0] code);
        op_dec_t d;
        d.kind     = KIND_NONE;
        d.from_imm = 1'b0;
        case (code)
            CODE_REV:     d.kind = KIND_REV;
            CODE_BYTE_IM: begin d.kind = KIND_BYTE; d.from_imm = 1'b1; end
            CODE_BYTE_RG: d.kind = KIND_BYTE;
            CODE_HALF_IM: begin d.kind = KIND_HALF; d.from_imm = 1'b1; end
            CODE_HALF_RG: d.kind = KIND_HALF;
            default:      d.kind = KIND_NONE;
        endcase
        return d;
    endfunction

    function automatic logic [HALF_W-1:0] sext_imm(input logic [IMM_W-1:0] imm);
        return {{(HALF_W-IMM_W){imm[IMM_W-1]}}, imm};
    endfunction

endpackage

// File: rtl/dsp_brr_decode.sv
module dsp_brr_decode
    import dsp_bitrep_pkg::*;
#(
    parameter int unsigned IDX_W = 5
) (
    input  logic [SUBOP_W-1:0] subop_i,
    input  logic [IDX_W-1:0]   dest_idx_i,
    input  logic               dsp_en_i,
    output op_dec_t            dec_o,
    output op_ctl_t            ctl_o
);

    logic known;
    logic dest_live;

    always_comb begin
        dec_o     = decode_subop(subop_i);
        known     = (dec_o.kind != KIND_NONE);
        dest_live = (dest_idx_i != '0);
        ctl_o.rsvd     = !known;
        ctl_o.write    = known && dest_live && dsp_en_i;
        ctl_o.unusable = known && dest_live && !dsp_en_i;
    end

    always_comb begin
        if (!$isunknown({subop_i, dest_idx_i, dsp_en_i})) begin
            // R7: index 0 never writes and never traps as disabled
            p_dest0_silent_r7: assert (dest_idx_i != '0 || (!ctl_o.write && !ctl_o.unusable));
            // R8: a reserved code never comes with an immediate kind
            p_rsvd_no_imm_r8: assert (!ctl_o.rsvd || !dec_o.from_imm);
        end
    end

endmodule

// File: rtl/dsp_brr_reverse.sv
module dsp_brr_reverse #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned REV_W  = 16
) (
    input  logic [REV_W-1:0]  src_i,
    output logic [DATA_W-1:0] rev_o
);

    localparam int unsigned PAD_W = DATA_W - REV_W;

    logic [REV_W-1:0] mirrored;

    for (genvar g = 0; g < REV_W; g++) begin : g_mirror
        assign mirrored[REV_W-1-g] = src_i[g];
    end

    assign rev_o = {{PAD_W{1'b0}}, mirrored};

    always_comb begin
        if (!$isunknown(src_i)) begin
            // R2: mirroring moves bits but keeps their number
            p_popcount_kept_r2: assert ($countones(rev_o) == $countones(src_i));
        end
    end

endmodule

// File: rtl/dsp_brr_replicate.sv
module dsp_brr_replicate
    import dsp_bitrep_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [HALF_W-1:0] src_i,
    input  op_dec_t           dec_i,
    output logic [DATA_W-1:0] rep_o
);

    localparam int unsigned N_BYTES = DATA_W / BYTE_W;
    localparam int unsigned N_HALFS = DATA_W / HALF_W;

    logic [BYTE_W-1:0] byte_val;
    logic [HALF_W-1:0] half_val;
    logic [DATA_W-1:0] byte_rep;
    logic [DATA_W-1:0] half_rep;

    always_comb begin
        byte_val = dec_i.from_imm ? imm_i[BYTE_W-1:0] : src_i[BYTE_W-1:0];
        half_val = dec_i.from_imm ? sext_imm(imm_i)   : src_i;
    end

    for (genvar b = 0; b < N_BYTES; b++) begin : g_byte_lane
        assign byte_rep[b*BYTE_W +: BYTE_W] = byte_val;
    end

    for (genvar h = 0; h < N_HALFS; h++) begin : g_half_lane
        assign half_rep[h*HALF_W +: HALF_W] = half_val;
    end

    assign rep_o = (dec_i.kind == KIND_HALF) ? half_rep : byte_rep;

    always_comb begin
        if (!$isunknown({imm_i, src_i, dec_i})) begin
            // R3 / R4: every byte lane matches the lowest one in byte mode
            p_byte_lanes_r3: assert (dec_i.kind != KIND_BYTE ||
                                     rep_o == {N_BYTES{rep_o[BYTE_W-1:0]}});
            // R5 / R6: both halfword lanes match in halfword mode
            p_half_lanes_r6: assert (dec_i.kind != KIND_HALF ||
                                     rep_o == {N_HALFS{rep_o[HALF_W-1:0]}});
        end
    end

endmodule

// File: rtl/dsp_bitrep_unit.sv
module dsp_bitrep_unit
    import dsp_bitrep_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned IDX_W     = 5,
    parameter int unsigned SUBOP_LSB = 6,
    parameter int unsigned IMM_LSB   = 16
) (
    input  logic [DATA_W-1:0] instr_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [IDX_W-1:0]  dest_idx_i,
    input  logic              dsp_en_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o,
    output logic              rsvd_instr_o,
    output logic              dsp_unusable_o
);

    op_dec_t           dec;
    op_ctl_t           ctl;
    logic [DATA_W-1:0] rev_val;
    logic [DATA_W-1:0] rep_val;
    logic              unused_instr;
    logic              unused_src;

    assign unused_instr = ^instr_i;
    assign unused_src   = ^src_i;

    dsp_brr_decode #(
        .IDX_W (IDX_W)
    ) u_decode (
        .subop_i    (instr_i[SUBOP_LSB +: SUBOP_W]),
        .dest_idx_i (dest_idx_i),
        .dsp_en_i   (dsp_en_i),
        .dec_o      (dec),
        .ctl_o      (ctl)
    );

    dsp_brr_reverse #(
        .DATA_W (DATA_W),
        .REV_W  (HALF_W)
    ) u_reverse (
        .src_i (src_i[HALF_W-1:0]),
        .rev_o (rev_val)
    );

    dsp_brr_replicate #(
        .DATA_W (DATA_W)
    ) u_replicate (
        .imm_i (instr_i[IMM_LSB +: IMM_W]),
        .src_i (src_i[HALF_W-1:0]),
        .dec_i (dec),
        .rep_o (rep_val)
    );

    always_comb begin
        wr_en_o        = ctl.write;
        rsvd_instr_o   = ctl.rsvd;
        dsp_unusable_o = ctl.unusable;
        if (!ctl.write)
            result_o = '0;
        else if (dec.kind == KIND_REV)
            result_o = rev_val;
        else
            result_o = rep_val;
    end

    always_comb begin
        if (!$isunknown({instr_i, src_i, dest_idx_i, dsp_en_i})) begin
            p_flags_onehot_r10: assert ($onehot0({wr_en_o, rsvd_instr_o, dsp_unusable_o}));
            p_quiet_result_r10: assert (wr_en_o || result_o == '0);
            p_disabled_nowrite_r9: assert (dsp_en_i || !wr_en_o);
            p_rev_upper_zero_r2: assert (!(wr_en_o && instr_i[SUBOP_LSB +: SUBOP_W] == CODE_REV)
                                         || result_o[DATA_W-1:HALF_W] == '0);
        end
    end

endmodule

// File: tb/tb_dsp_bitrep_unit.sv
module tb_dsp_bitrep_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr;
    logic [31:0] src;
    logic [4:0]  dest;
    logic        en;
    logic [31:0] result;
    logic        wr_en, rsvd, unus;

    int unsigned n_checks = 0;
    int unsigned n_errors = 0;

    always #2 clk = ~clk;

    dsp_bitrep_unit dut (
        .instr_i        (instr),
        .src_i          (src),
        .dest_idx_i     (dest),
        .dsp_en_i       (en),
        .result_o       (result),
        .wr_en_o        (wr_en),
        .rsvd_instr_o   (rsvd),
        .dsp_unusable_o (unus)
    );

    function automatic logic [31:0] mk_instr(input logic [4:0] code, input logic [9:0] imm);
        return {6'b011111, imm, 5'b00000, code, 6'b010010};
    endfunction

    // expected {result, wr_en, rsvd, unusable}
    function automatic logic [34:0] model(input logic [31:0] i, input logic [31:0] s,
                                          input logic [4:0] d, input logic e);
        logic [31:0] r;
        logic        known;
        logic [15:0] h;
        known = 1'b1;
        r = 32'h0;
        case (i[10:6])
            5'h1B: for (int k = 0; k < 16; k++) r[15-k] = s[k];
            5'h02: r = {4{i[23:16]}};
            5'h03: r = {4{s[7:0]}};
            5'h0A: begin h = {{6{i[25]}}, i[25:16]}; r = {h, h}; end
            5'h0B: r = {s[15:0], s[15:0]};
            default: known = 1'b0;
        endcase
        if (!known)   return {32'h0, 1'b0, 1'b1, 1'b0};
        if (d == 5'd0) return {32'h0, 1'b0, 1'b0, 1'b0};
        if (!e)       return {32'h0, 1'b0, 1'b0, 1'b1};
        return {r, 1'b1, 1'b0, 1'b0};
    endfunction

    function automatic string tag_of(input logic [4:0] c);
        case (c)
            5'h1B: return "R2";
            5'h02: return "R3";
            5'h03: return "R4";
            5'h0A: return "R5";
            5'h0B: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic run(input logic [31:0] i, input logic [31:0] s, input logic [4:0] d,
                       input logic e, input string tag);
        logic [34:0] act, exp;
        @(negedge clk);
        instr = i; src = s; dest = d; en = e;
        #1;
        act = {result, wr_en, rsvd, unus};
        exp = model(i, s, d, e);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s instr=%h src=%h dest=%0d en=%0b actual=%h expected=%h",
                     tag, i, s, d, e, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [4:0] codes [5];
        void'($urandom(32'd7321));
        codes[0] = 5'h1B; codes[1] = 5'h02; codes[2] = 5'h03;
        codes[3] = 5'h0A; codes[4] = 5'h0B;
        instr = 32'h0; src = 32'h0; dest = 5'd0; en = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // idle inputs: code 0 is unknown, R8
        run(32'h0, 32'h0, 5'd0, 1'b0, "R8 reset state");
        // R2 reverse, upper source bits ignored
        run(mk_instr(5'h1B, 10'h0), 32'hFFFF_0001, 5'd3, 1'b1, "R2 single bit");
        run(mk_instr(5'h1B, 10'h0), 32'h1234_ABCD, 5'd3, 1'b1, "R2 pattern");
        // R3 byte immediate
        run(mk_instr(5'h02, 10'h3A5), 32'hDEAD_BEEF, 5'd4, 1'b1, "R3 byte imm");
        // R4 byte register
        run(mk_instr(5'h03, 10'h000), 32'h1234_5681, 5'd5, 1'b1, "R4 byte reg");
        // R5 sign bit set and clear
        run(mk_instr(5'h0A, 10'h200), 32'h0, 5'd6, 1'b1, "R5 negative imm");
        run(mk_instr(5'h0A, 10'h1FF), 32'h0, 5'd6, 1'b1, "R5 positive imm");
        // R6 halfword register
        run(mk_instr(5'h0B, 10'h0), 32'hCAFE_8001, 5'd7, 1'b1, "R6 half reg");
        // R7 destination 0, enabled and disabled
        run(mk_instr(5'h03, 10'h0), 32'hFFFF_FFFF, 5'd0, 1'b1, "R7 dest zero");
        run(mk_instr(5'h1B, 10'h0), 32'hFFFF_FFFF, 5'd0, 1'b0, "R7 dest zero disabled");
        // R1 neighbours of the reverse code are unknown
        run(mk_instr(5'h1A, 10'h0), 32'h5555_5555, 5'd9, 1'b1, "R1 code 1A");
        run(mk_instr(5'h1C, 10'h0), 32'h5555_5555, 5'd9, 1'b1, "R1 code 1C");
        // R8 unknown code beats disabled and dest 0
        run(mk_instr(5'h0C, 10'h0), 32'h1, 5'd2, 1'b0, "R8 unknown disabled");
        run(mk_instr(5'h1F, 10'h0), 32'h1, 5'd0, 1'b1, "R8 unknown dest zero");
        // R9 disabled with live destination
        run(mk_instr(5'h0B, 10'h0), 32'h8765_4321, 5'd31, 1'b0, "R9 disabled");
        // R10 full write of a max index
        run(mk_instr(5'h02, 10'h0FF), 32'h0, 5'd31, 1'b1, "R10 write max idx");

        for (int n = 0; n < 3000; n++) begin
            logic [4:0]  c;
            logic [4:0]  d;
            logic [31:0] i;
            c = ($urandom_range(0, 9) < 8) ? codes[$urandom_range(0, 4)] : 5'($urandom);
            d = ($urandom_range(0, 7) == 0) ? 5'd0 : 5'($urandom);
            i = $urandom;
            i[10:6] = c;
            run(i, $urandom, d, ($urandom_range(0, 5) != 0), tag_of(c));
        end

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule